// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the write cycles a host makes on a parallel NOR flash bus. It recognises the command sequences that begin with a two-write unlock prefix, and it also recognises a few single-write commands. Each recognised command becomes a one-cycle operation request for the embedded program/erase engine. The request carries the latched target address and data, and for sector erase it also carries a mask of the selected sectors. The decoder also holds two level flags: one says the device is in identification (autoselect) mode, and one says a running erase has been suspended.

The write strobe is active low and is sampled on the system clock. Each falling edge of the strobe is one bus write, and the address and data are captured in that cycle. The decoder does not model the memory array, the algorithm timing or the high-voltage paths. The engine's busy signal is an input. The decoder uses it to ignore commands while an operation is running, and to decide whether a suspend request is valid.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `op_valid`, `op_kind`, `op_mask`, `autosel` and `suspended` are all 0.
- R2: A low level on `we_n` that lasts several clock cycles counts as a single bus write, taken in the first clock cycle that `we_n` is sampled low.
- R3: The first-unlock and command address is 555h on address bits 10:0 in word mode (`byte_mode`=0) and AAAh on bits 11:0 in byte mode. The second-unlock address is 2AAh on bits 10:0 in word mode and 555h on bits 11:0 in byte mode. Higher address bits are ignored in these matches. The unlock data are AAh then 55h, and only data bits 7:0 are compared for any command.
- R4: Unlock, then A0h at the command address, then any fourth write, issues a program request. Here `op_kind`=1 and `op_addr`/`op_data` carry that fourth write, even when its data is F0h. `op_valid` is high for exactly the one cycle after the fourth write.
- R5: Unlock, 80h, unlock, then 10h at the command address issues a chip-erase request (`op_kind`=2) with `op_mask`=0.
- R6: Unlock, 80h, unlock, then 30h at any address starts sector gathering. Each further 30h write adds a sector. The sector index is the word address shifted right by `SECT_LSB`, where the word address is `wr_addr` shifted right by one in byte mode. A sector-erase request (`op_kind`=3) is issued `TMO_CYC` cycles after the last 30h write, with bit i of `op_mask` set for each selected sector i and `op_addr` set to the last sector address.
- R7: A write of F0h issues a reset request (`op_kind`=6) and clears `autosel`. This applies as a single write, after the unlock prefix, or at any other point in a sequence except as program data.
- R8: Unlock followed by 90h at the command address sets `autosel` to 1 and issues no request.
- R9: A write that does not fit the expected next step of a sequence abandons that sequence, clears `autosel` and issues no request. This includes a non-30h write during sector gathering. In the idle state, writes that start nothing are ignored.
- R10: While `busy` is 1, every write other than an accepted suspend is ignored. No request is issued and the sequence state does not advance.
- R11: B0h written while `busy` is 1 and an erase issued by this decoder is running issues a suspend request (`op_kind`=4) and sets `suspended`. B0h at any other time causes neither.
- R12: While `suspended` is 1 and the decoder is idle, a write of 30h issues a resume request (`op_kind`=5) and clears `suspended`. The erase counts as finished when `busy` falls while not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe; a falling edge is one bus write |
| wr_addr | input | ADDR_W | Bus address (byte address in byte mode) |
| wr_data | input | DATA_W | Bus write data |
| byte_mode | input | 1 | 1 selects byte-mode address interpretation |
| busy | input | 1 | Embedded engine running an operation |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | DATA_W | Program data of the request |
| op_mask | output | 2**(ADDR_W-1-SECT_LSB) | Selected sectors of a sector-erase request |
| autosel | output | 1 | Autoselect mode flag |
| suspended | output | 1 | Erase-suspended flag |

## Verification
Program sequences are applied in word and byte mode, with unlock addresses that carry random upper bits. This separates masking of the upper bits from a full-width compare. Unlock writes are also placed at the address of the other mode, which must not be accepted. Program data of F0h separates "any fourth write" from the reset shortcut. A strobe held low for several cycles separates edge detection from level detection. Sector gathering is tried in both modes, with the request timed cycle by cycle, and with a stray write that must cancel it. Suspend is tried with and without a running erase, which separates the erase-ownership rule from a plain busy check. Busy-time program attempts confirm that writes are ignored while the engine runs.

// File: rtl/ncd_pkg.sv
package ncd_pkg;

  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_PROGRAM      = 3'd1,
    OP_CHIP_ERASE   = 3'd2,
    OP_SECTOR_ERASE = 3'd3,
    OP_SUSPEND      = 3'd4,
    OP_RESUME       = 3'd5,
    OP_RESET        = 3'd6
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3, S_GATHER
  } seq_state_e;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  // Unlock/command address match on the low address bits only.
  function automatic logic key_addr_hit(input logic [11:0] low,
                                        input logic       byte_mode,
                                        input logic       second);
    logic hit;
    if (byte_mode) hit = (low == (second ? 12'h555 : 12'hAAA));
    else           hit = (low[10:0] == (second ? 11'h2AA : 11'h555));
    return hit;
  endfunction

endpackage

// File: rtl/ncd_strobe_edge.sv
module ncd_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  output logic wr_evt
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_evt = we_q & ~we_n;

  // R2: a held-low strobe never yields two events back to back
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/ncd_unlock_match.sv
module ncd_unlock_match
  import ncd_pkg::*;
(
  input  logic [11:0] addr_low,
  input  logic        byte_mode,
  output logic        hit_first,
  output logic        hit_second
);
  assign hit_first  = key_addr_hit(addr_low, byte_mode, 1'b0);
  assign hit_second = key_addr_hit(addr_low, byte_mode, 1'b1);

  // R3: one address can never match both unlock positions
  always_comb begin
    a_exclusive_r3: assert (!(hit_first && hit_second));
  end
endmodule

// File: rtl/ncd_sector_mask.sv
module ncd_sector_mask #(
  parameter int SIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              add,
  input  logic [SIDX_W-1:0] sidx,
  output logic [(1<<SIDX_W)-1:0] mask
);
  localparam int NSECT = 1 << SIDX_W;

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mask[i] <= 1'b0;
      else if (start)                      mask[i] <= (sidx == SIDX_W'(i));
      else if (add && sidx == SIDX_W'(i))  mask[i] <= 1'b1;
    end
  end

  // R6: a start always leaves exactly the addressed sector selected
  p_start_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> $countones(mask) == 1);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import ncd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 15,
  parameter int TMO_CYC  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  byte_mode,
  input  logic                  busy,
  output logic                  op_valid,
  output logic [2:0]            op_kind,
  output logic [ADDR_W-1:0]     op_addr,
  output logic [DATA_W-1:0]     op_data,
  output logic [(1<<(ADDR_W-1-SECT_LSB))-1:0] op_mask,
  output logic                  autosel,
  output logic                  suspended
);
  localparam int WA_W   = ADDR_W - 1;
  localparam int SIDX_W = WA_W - SECT_LSB;
  localparam int NSECT  = 1 << SIDX_W;
  localparam int TMR_W  = $clog2(TMO_CYC + 1);

  logic wr_evt, hit_a, hit_b;
  logic [7:0] cmd;
  logic [WA_W-1:0] waddr;
  logic [SIDX_W-1:0] sidx;
  logic [NSECT-1:0] mask_q;

  seq_state_e st, st_n;
  op_kind_e   kind_n, op_kind_q;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic issue, as_set, as_clr, mask_start, mask_add;
  logic erase_run, busy_q, accept_susp, seq_go;
  logic [ADDR_W-1:0] last_sect_addr;

  ncd_strobe_edge u_edge (.clk(clk), .rst_n(rst_n), .we_n(we_n), .wr_evt(wr_evt));

  ncd_unlock_match u_match (
    .addr_low(wr_addr[11:0]), .byte_mode(byte_mode),
    .hit_first(hit_a), .hit_second(hit_b));

  assign cmd   = wr_data[7:0];
  assign waddr = byte_mode ? wr_addr[ADDR_W-1:1] : wr_addr[ADDR_W-2:0];
  assign sidx  = waddr[WA_W-1:SECT_LSB];

  ncd_sector_mask #(.SIDX_W(SIDX_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .start(mask_start), .add(mask_add),
    .sidx(sidx), .mask(mask_q));

  assign accept_susp = wr_evt && cmd == CMD_SUSPEND && busy && erase_run && !suspended;
  assign seq_go      = wr_evt && !busy;

  always_comb begin
    st_n = st; tmr_n = tmr; issue = 1'b0; kind_n = OP_NONE;
    as_set = 1'b0; as_clr = 1'b0; mask_start = 1'b0; mask_add = 1'b0;
    if (accept_susp) begin
      issue = 1'b1; kind_n = OP_SUSPEND;
    end else if (seq_go) begin
      tmr_n = '0;
      if (st != S_PROG && cmd == CMD_RESET) begin
        issue = 1'b1; kind_n = OP_RESET; st_n = S_IDLE; as_clr = 1'b1;
      end else begin
        st_n = S_IDLE;
        unique case (st)
          S_IDLE: begin
            if (cmd == CMD_KEY_A && hit_a) st_n = S_UNL1;
            else if (cmd == CMD_SECTOR && suspended) begin
              issue = 1'b1; kind_n = OP_RESUME;
            end
          end
          S_UNL1: if (cmd == CMD_KEY_B && hit_b) st_n = S_UNL2; else as_clr = 1'b1;
          S_UNL2: begin
            if (hit_a && cmd == CMD_PROGRAM)    st_n = S_PROG;
            else if (hit_a && cmd == CMD_ERASE) st_n = S_ER1;
            else if (hit_a && cmd == CMD_IDENT) as_set = 1'b1;
            else                                as_clr = 1'b1;
          end
          S_PROG: begin issue = 1'b1; kind_n = OP_PROGRAM; end
          S_ER1: if (cmd == CMD_KEY_A && hit_a) st_n = S_ER2; else as_clr = 1'b1;
          S_ER2: if (cmd == CMD_KEY_B && hit_b) st_n = S_ER3; else as_clr = 1'b1;
          S_ER3: begin
            if (cmd == CMD_CHIP && hit_a) begin issue = 1'b1; kind_n = OP_CHIP_ERASE; end
            else if (cmd == CMD_SECTOR) begin st_n = S_GATHER; mask_start = 1'b1; end
            else as_clr = 1'b1;
          end
          S_GATHER: begin
            if (cmd == CMD_SECTOR) begin st_n = S_GATHER; mask_add = 1'b1; end
            else as_clr = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (st == S_GATHER) begin
      if (tmr == TMR_W'(TMO_CYC - 1)) begin
        issue = 1'b1; kind_n = OP_SECTOR_ERASE; st_n = S_IDLE; tmr_n = '0;
      end else begin
        tmr_n = tmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; op_valid <= 1'b0; op_kind_q <= OP_NONE;
      op_addr <= '0; op_data <= '0; op_mask <= '0; last_sect_addr <= '0;
    end else begin
      st <= st_n; tmr <= tmr_n; op_valid <= issue;
      if (mask_start || mask_add) last_sect_addr <= wr_addr;
      if (issue) begin
        op_kind_q <= kind_n;
        op_addr   <= (kind_n == OP_SECTOR_ERASE) ? last_sect_addr : wr_addr;
        op_data   <= (kind_n == OP_PROGRAM) ? wr_data : '0;
        op_mask   <= (kind_n == OP_SECTOR_ERASE) ? mask_q : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autosel <= 1'b0; suspended <= 1'b0; erase_run <= 1'b0; busy_q <= 1'b0;
    end else begin
      busy_q <= busy;
      if (as_set) autosel <= 1'b1;
      else if (as_clr) autosel <= 1'b0;
      if (issue && kind_n == OP_SUSPEND)     suspended <= 1'b1;
      else if (issue && kind_n == OP_RESUME) suspended <= 1'b0;
      if (issue && (kind_n == OP_CHIP_ERASE || kind_n == OP_SECTOR_ERASE)) erase_run <= 1'b1;
      else if (busy_q && !busy && !suspended)                              erase_run <= 1'b0;
    end
  end

  assign op_kind = op_kind_q;

  // R10: a busy-time write that is not an accepted suspend yields no request
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_evt && !accept_susp && st != S_GATHER) |=> !op_valid);
  // R11: a suspend request is always accompanied by the suspended flag
  p_suspend_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind_q == OP_SUSPEND) |-> suspended);
  // R12: a resume request leaves the flag cleared
  p_resume_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind_q == OP_RESUME) |-> !suspended);
  // R8: entering autoselect never coincides with a request
  p_ident_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autosel) |-> !op_valid);
  // R7: after a reset request autoselect is off
  p_reset_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind_q == OP_RESET) |-> !autosel);
  // R6: a sector-erase request selects at least one sector
  p_mask_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind_q == OP_SECTOR_ERASE) |-> op_mask != '0);
endmodule

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb;
  localparam int ADDR_W = 20, DATA_W = 16, SECT_LSB = 15, TMO_CYC = 8;
  localparam int NSECT = 1 << (ADDR_W - 1 - SECT_LSB);

  logic clk = 1'b0, rst_n = 1'b0, we_n = 1'b1, byte_mode = 1'b0, busy = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic op_valid, autosel, suspended;
  logic [2:0] op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [NSECT-1:0] op_mask;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .TMO_CYC(TMO_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_mode(byte_mode), .busy(busy), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_mask(op_mask), .autosel(autosel),
    .suspended(suspended));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus write; returns at the negedge where its result is visible.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic unlock(input logic [ADDR_W-1:0] hi);
    if (byte_mode) begin wr(hi | 20'hAAA, 16'hAA); wr(hi | 20'h555, 16'h55); end
    else           begin wr(hi | 20'h555, 16'hAA); wr(hi | 20'h2AA, 16'h55); end
  endtask

  function automatic logic [ADDR_W-1:0] cmd_a(input logic [ADDR_W-1:0] hi);
    return hi | (byte_mode ? 20'hAAA : 20'h555);
  endfunction

  task automatic t_reset;
    chk("R1 op_valid", op_valid, 0); chk("R1 op_kind", op_kind, 0);
    chk("R1 op_mask", op_mask, 0); chk("R1 autosel", autosel, 0);
    chk("R1 suspended", suspended, 0);
  endtask

  task automatic t_program_word;
    byte_mode = 0;
    unlock(20'h31000); wr(cmd_a(20'h4A000), 16'hA0); chk("R4 no early op", op_valid, 0);
    wr(20'h12345, 16'hBEEF);
    chk("R4 valid", op_valid, 1); chk("R4 kind", op_kind, 1);
    chk("R4 addr", op_addr, 20'h12345); chk("R4 data", op_data, 16'hBEEF);
    @(negedge clk); chk("R4 one cycle", op_valid, 0);
    unlock(0); wr(cmd_a(0), 16'hA0); wr(20'h00777, 16'h00F0);
    chk("R4 F0 data kind", op_kind, 1); chk("R4 F0 data", op_data, 16'h00F0);
  endtask

  task automatic t_program_byte;
    byte_mode = 1;
    unlock(20'hF0000); wr(cmd_a(20'h73000), 16'hA0); wr(20'h8ABCD, 16'h005A);
    chk("R3 byte-mode program kind", op_kind, 1); chk("R3 byte valid", op_valid, 1);
    chk("R3 byte addr", op_addr, 20'h8ABCD);
    byte_mode = 0;
  endtask

  task automatic t_held_strobe;
    int pulses = 0;
    unlock(0); wr(cmd_a(0), 16'hA0);
    @(negedge clk); wr_addr = 20'h00100; wr_data = 16'h1234; we_n = 1'b0;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (op_valid) pulses++; end
    we_n = 1'b1;
    for (int k = 0; k < 3; k++) begin @(negedge clk); if (op_valid) pulses++; end
    chk("R2 held strobe single request", pulses, 1);
  endtask

  task automatic t_autoselect;
    unlock(0); wr(cmd_a(20'h70000), 16'h90);
    chk("R8 autosel set", autosel, 1); chk("R8 no request", op_valid, 0);
    wr(20'h33333, 16'hF0);
    chk("R7 single reset kind", op_kind, 6); chk("R7 valid", op_valid, 1);
    chk("R7 autosel cleared", autosel, 0);
    unlock(0); wr(20'h01234, 16'hF0);
    chk("R7 unlock reset kind", op_kind, 6); chk("R7 unlock reset valid", op_valid, 1);
  endtask

  task automatic t_wrong_mode_addr;
    byte_mode = 0;
    wr(20'h00AAA, 16'hAA); wr(20'h00555, 16'h55); wr(20'h00AAA, 16'h90);
    chk("R3 byte addresses rejected in word mode", autosel, 0);
    byte_mode = 1;
    wr(20'h00555, 16'hAA); wr(20'h002AA, 16'h55); wr(20'h00555, 16'h90);
    chk("R3 word addresses rejected in byte mode", autosel, 0);
    byte_mode = 0;
  endtask

  task automatic t_abort;
    int seen = 0;
    unlock(0); wr(cmd_a(0), 16'h90); chk("R9 setup autosel", autosel, 1);
    wr(cmd_a(0), 16'hAA); wr(cmd_a(0), 16'h77);
    chk("R9 abort clears autosel", autosel, 0); chk("R9 abort no op", op_valid, 0);
    wr(cmd_a(0), 16'hA0); wr(20'h00010, 16'h1111);
    chk("R9 idle after abort", op_valid, 0);
    unlock(0); wr(cmd_a(0), 16'h80); unlock(0); wr(20'h08000, 16'h30);
    wr(20'h10000, 16'h55);
    for (int k = 0; k < TMO_CYC + 3; k++) begin @(negedge clk); if (op_valid) seen++; end
    chk("R9 gather cancelled", seen, 0);
  endtask

  task automatic t_chip_erase;
    unlock(0); wr(cmd_a(0), 16'h80); unlock(0); wr(cmd_a(20'h20000), 16'h10);
    chk("R5 valid", op_valid, 1); chk("R5 kind", op_kind, 2); chk("R5 mask", op_mask, 0);
  endtask

  task automatic t_sector_erase(input logic bm, input logic [ADDR_W-1:0] a1,
                                input logic [ADDR_W-1:0] a2, input logic [NSECT-1:0] emask);
    int when = -1;
    byte_mode = bm;
    unlock(0); wr(cmd_a(0), 16'h80); unlock(0); wr(a1, 16'h30); wr(a2, 16'h30);
    for (int k = 1; k <= TMO_CYC + 2; k++) begin
      @(negedge clk); if (op_valid && when < 0) when = k;
    end
    chk("R6 request timing", when, TMO_CYC);
    chk("R6 kind", op_kind, 3); chk("R6 mask", op_mask, emask); chk("R6 addr", op_addr, a2);
    byte_mode = 0;
  endtask

  task automatic t_busy;
    int seen = 0;
    busy = 1;
    unlock(0); wr(cmd_a(0), 16'hA0); wr(20'h00200, 16'h2222); wr(20'h00000, 16'hF0);
    for (int k = 0; k < 2; k++) begin @(negedge clk); if (op_valid) seen++; end
    busy = 0;
    wr(20'h00200, 16'h2222);
    chk("R10 busy writes ignored", seen + op_valid, 0);
  endtask

  task automatic t_suspend;
    busy = 1; @(negedge clk); busy = 0; @(negedge clk);
    busy = 1; wr(20'h40000, 16'hB0);
    chk("R11 no erase, no suspend", op_valid, 0); chk("R11 flag stays low", suspended, 0);
    busy = 0;
    unlock(0); wr(cmd_a(0), 16'h80); unlock(0); wr(cmd_a(0), 16'h10);
    chk("R11 setup erase", op_kind, 2);
    busy = 1; @(negedge clk);
    wr(20'h40000, 16'hB0);
    chk("R11 suspend kind", op_kind, 4); chk("R11 suspend valid", op_valid, 1);
    chk("R11 suspended set", suspended, 1);
    busy = 0; @(negedge clk);
    wr(20'h40000, 16'h30);
    chk("R12 resume kind", op_kind, 5); chk("R12 resume valid", op_valid, 1);
    chk("R12 suspended cleared", suspended, 0);
    busy = 1; @(negedge clk); busy = 0; @(negedge clk);
    wr(20'h40000, 16'h30);
    chk("R12 no resume when not suspended", op_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; @(negedge clk);
    t_reset();
    t_program_word();
    t_program_byte();
    t_held_strobe();
    t_autoselect();
    t_wrong_mode_addr();
    t_abort();
    t_chip_erase();
    t_sector_erase(1'b0, 20'h18000, 20'h40000, 16'h0108);
    t_sector_erase(1'b1, 20'h48000, 20'h48000, 16'h0010);
    t_busy();
    t_suspend();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule